// File: doc/BRIEF.md
# Loopback and Alarm Override Path

This block sits between the encoder of a DS3/E3 transmit framer and two consumers: the transmit line outputs (a positive and a negative rail) and the receive decoder inputs. It selects what each path carries and applies alarm overrides to it. The overrides are all-ones AIS, an idle pattern, an RAI pattern and loss-of-signal zero forcing. It also decides whether an error-insertion request is honoured. Each rail is a `W`-bit word per clock. All outputs are registered, so they appear one cycle after the inputs.

The control inputs are static configuration bits: source loopback, shallow line loopback, payload loopback, a two-bit alarm select and a LOS force. These bits only take effect when the frame-boundary strobe `frame_sync` is high, so neither path ever carries a partial frame. A small state machine holds the active loopback mode. Its states are MODE_NORMAL, MODE_SOURCE, MODE_SHALLOW and MODE_PAYLOAD. On a cycle where `frame_sync` is high, any state moves to MODE_SHALLOW if shallow loopback is requested. Otherwise it moves to MODE_SOURCE if source loopback is requested, otherwise to MODE_PAYLOAD if payload loopback is requested, and otherwise to MODE_NORMAL. Without the strobe every state holds. Alarm patterns are produced only on explicit configuration and never in reaction to anything the receiver sees.

In source loopback the overrides are applied asymmetrically. AIS and LOS change only the line outputs, and the looped frame keeps the encoder data. Idle and RAI overwrite both paths. The looped path is timed by the transmit clock alone and needs no dejitter stage.

Top module: `lpbk_alarm_path`

## Requirements
- R1: While `rst_n` is low, all four rail outputs, `err_applied` and `lp_conflict` are zero, and the active configuration returns to MODE_NORMAL with no alarm and no LOS.
- R2: The request inputs are captured into the active configuration only on a clock edge where `frame_sync` is 1. Every output reflects the data inputs and the active configuration of the previous clock edge.
- R3: In MODE_SOURCE with no alarm, no LOS and no error, both the line outputs and the decoder outputs equal the encoder rails.
- R4: In MODE_SOURCE with alarm select 2'b01 (AIS), the line positive rail is all ones and the line negative rail is all zeros. The decoder outputs keep the encoder rails.
- R5: With LOS active, both line rails are zero in every mode. In MODE_SOURCE the decoder outputs keep the encoder rails (or the idle/RAI pattern, if one is selected).
- R6: In MODE_SOURCE, alarm select 2'b10 (idle: positive rail has its odd bits set, negative rail has its even bits set) and 2'b11 (RAI: positive rail zero, negative rail all ones) replace both the line and the decoder outputs, unless LOS zeroes the line.
- R7: An error request inverts bit 0 of the positive rail of unpatterned data. This applies to the line in MODE_NORMAL, MODE_SOURCE and MODE_PAYLOAD, and to the decoder path in MODE_SOURCE. The request is ignored and `err_applied` stays 0 when LOS is active, when any alarm is selected, or in MODE_SHALLOW.
- R8: In MODE_PAYLOAD the line outputs carry the receive rails, with LOS, AIS, idle and RAI overrides applied in that priority order. The decoder outputs carry the receive rails.
- R9: Shallow loopback has priority over source loopback, and source loopback has priority over payload loopback. In MODE_SHALLOW the line carries the receive rails, and only LOS overrides them. A strobe with shallow and source both requested sets `lp_conflict`, which stays set until reset.
- R10: In MODE_NORMAL the decoder outputs carry the receive rails. The line outputs carry the encoder rails with the override priority LOS, then AIS, then idle/RAI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit output clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_sync | input | 1 | Frame boundary strobe; enables configuration capture |
| cfg_src_lp | input | 1 | Source loopback request |
| cfg_shallow_lp | input | 1 | Shallow line loopback request |
| cfg_payload_lp | input | 1 | Payload loopback request |
| cfg_alarm | input | 2 | Alarm select: 00 none, 01 AIS, 10 idle, 11 RAI |
| cfg_los | input | 1 | Force line outputs to zero |
| err_req | input | 1 | Error insertion request |
| enc_pos | input | W | Encoder positive rail |
| enc_neg | input | W | Encoder negative rail |
| rx_pos | input | W | Receive positive rail |
| rx_neg | input | W | Receive negative rail |
| line_pos | output | W | Transmit line positive rail |
| line_neg | output | W | Transmit line negative rail |
| dec_pos | output | W | Receive decoder positive rail |
| dec_neg | output | W | Receive decoder negative rail |
| err_applied | output | 1 | Error insertion honoured on this output word |
| lp_conflict | output | 1 | Sticky: shallow and source requested together |

## Verification
Two functions can fall in the same cycle: error insertion and alarm generation. The sharpest case is in source loopback, where AIS or LOS alters only the line, yet an error request in that same cycle must be dropped from both paths. The bench provokes this with directed words that combine `err_req` with each alarm code and with LOS. It also raises all of these at random together with strobed mode changes. Each output word is judged against a bench model that keeps its own copy of the active configuration, captured on the strobe.

// File: rtl/lpbk_pkg.sv
package lpbk_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'd0,
        MODE_SOURCE  = 2'd1,
        MODE_SHALLOW = 2'd2,
        MODE_PAYLOAD = 2'd3
    } lp_mode_e;

    typedef enum logic [1:0] {
        ALM_NONE = 2'd0,
        ALM_AIS  = 2'd1,
        ALM_IDLE = 2'd2,
        ALM_RAI  = 2'd3
    } alarm_e;
endpackage

// File: rtl/lpbk_mode_fsm.sv
module lpbk_mode_fsm
    import lpbk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_sync,
    input  logic       req_src,
    input  logic       req_shallow,
    input  logic       req_payload,
    input  logic [1:0] req_alarm,
    input  logic       req_los,
    output lp_mode_e   mode_o,
    output alarm_e     alarm_o,
    output logic       los_o,
    output logic       conflict_o
);
    lp_mode_e state_q, state_d, target;
    alarm_e   alarm_q;
    logic     los_q, conflict_q;

    // Resolve the requested mode: shallow > source > payload > normal
    always_comb begin
        unique casez ({req_shallow, req_src, req_payload})
            3'b1??:  target = MODE_SHALLOW;
            3'b01?:  target = MODE_SOURCE;
            3'b001:  target = MODE_PAYLOAD;
            default: target = MODE_NORMAL;
        endcase
    end

    // Next state: every state follows the target on a strobe, holds otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_NORMAL,
            MODE_SOURCE,
            MODE_SHALLOW,
            MODE_PAYLOAD: if (frame_sync) state_d = target;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= MODE_NORMAL;
            alarm_q    <= ALM_NONE;
            los_q      <= 1'b0;
            conflict_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (frame_sync) begin
                alarm_q <= alarm_e'(req_alarm);
                los_q   <= req_los;
                if (req_shallow && req_src) conflict_q <= 1'b1;
            end
        end
    end

    assign mode_o     = state_q;
    assign alarm_o    = alarm_q;
    assign los_o      = los_q;
    assign conflict_o = conflict_q;
endmodule

// File: rtl/lpbk_override.sv
module lpbk_override
    import lpbk_pkg::*;
#(
    parameter int W = 8
) (
    input  lp_mode_e       mode,
    input  alarm_e         alarm,
    input  logic           los,
    input  logic           err_req,
    input  logic [W-1:0]   enc_p,
    input  logic [W-1:0]   enc_n,
    input  logic [W-1:0]   rx_p,
    input  logic [W-1:0]   rx_n,
    output logic [W-1:0]   line_p,
    output logic [W-1:0]   line_n,
    output logic [W-1:0]   dec_p,
    output logic [W-1:0]   dec_n,
    output logic           err_ok
);
    localparam int           HALF    = W / 2;
    localparam logic [W-1:0] ONES    = {W{1'b1}};
    localparam logic [W-1:0] IDLE_P  = {HALF{2'b10}};
    localparam logic [W-1:0] IDLE_N  = {HALF{2'b01}};
    localparam logic [W-1:0] ERR_BIT = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] emask, base_p, base_n;

    always_comb begin
        err_ok = err_req && (mode != MODE_SHALLOW) && !los && (alarm == ALM_NONE);
        emask  = err_ok ? ERR_BIT : '0;
        base_p = (mode == MODE_PAYLOAD) ? rx_p : enc_p;
        base_n = (mode == MODE_PAYLOAD) ? rx_n : enc_n;

        // Line path: LOS, then shallow pass-through, then alarm patterns
        if (los) begin
            line_p = '0;
            line_n = '0;
        end else if (mode == MODE_SHALLOW) begin
            line_p = rx_p;
            line_n = rx_n;
        end else begin
            unique case (alarm)
                ALM_AIS:  begin line_p = ONES;   line_n = '0;     end
                ALM_IDLE: begin line_p = IDLE_P; line_n = IDLE_N; end
                ALM_RAI:  begin line_p = '0;     line_n = ONES;   end
                default:  begin line_p = base_p ^ emask; line_n = base_n; end
            endcase
        end

        // Decoder path: only source loopback redirects it, and only idle/RAI touch it
        if (mode == MODE_SOURCE) begin
            unique case (alarm)
                ALM_IDLE: begin dec_p = IDLE_P; dec_n = IDLE_N; end
                ALM_RAI:  begin dec_p = '0;     dec_n = ONES;   end
                default:  begin dec_p = enc_p ^ emask; dec_n = enc_n; end
            endcase
        end else begin
            dec_p = rx_p;
            dec_n = rx_n;
        end
    end
endmodule

// File: rtl/lpbk_alarm_path.sv
module lpbk_alarm_path
    import lpbk_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_sync,
    input  logic         cfg_src_lp,
    input  logic         cfg_shallow_lp,
    input  logic         cfg_payload_lp,
    input  logic [1:0]   cfg_alarm,
    input  logic         cfg_los,
    input  logic         err_req,
    input  logic [W-1:0] enc_pos,
    input  logic [W-1:0] enc_neg,
    input  logic [W-1:0] rx_pos,
    input  logic [W-1:0] rx_neg,
    output logic [W-1:0] line_pos,
    output logic [W-1:0] line_neg,
    output logic [W-1:0] dec_pos,
    output logic [W-1:0] dec_neg,
    output logic         err_applied,
    output logic         lp_conflict
);
    lp_mode_e     mode_q;
    alarm_e       alarm_q;
    logic         los_q;
    logic [W-1:0] lp_d, ln_d, dp_d, dn_d;
    logic         err_d;

    lpbk_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_sync  (frame_sync),
        .req_src     (cfg_src_lp),
        .req_shallow (cfg_shallow_lp),
        .req_payload (cfg_payload_lp),
        .req_alarm   (cfg_alarm),
        .req_los     (cfg_los),
        .mode_o      (mode_q),
        .alarm_o     (alarm_q),
        .los_o       (los_q),
        .conflict_o  (lp_conflict)
    );

    lpbk_override #(.W(W)) u_ovr (
        .mode    (mode_q),
        .alarm   (alarm_q),
        .los     (los_q),
        .err_req (err_req),
        .enc_p   (enc_pos),
        .enc_n   (enc_neg),
        .rx_p    (rx_pos),
        .rx_n    (rx_neg),
        .line_p  (lp_d),
        .line_n  (ln_d),
        .dec_p   (dp_d),
        .dec_n   (dn_d),
        .err_ok  (err_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_pos    <= '0;
            line_neg    <= '0;
            dec_pos     <= '0;
            dec_neg     <= '0;
            err_applied <= 1'b0;
        end else begin
            line_pos    <= lp_d;
            line_neg    <= ln_d;
            dec_pos     <= dp_d;
            dec_neg     <= dn_d;
            err_applied <= err_d;
        end
    end
endmodule

// File: rtl/lpbk_alarm_path_chk.sv
module lpbk_alarm_path_chk
    import lpbk_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         frame_sync,
    input logic         cfg_src_lp,
    input logic         cfg_shallow_lp,
    input logic [W-1:0] enc_pos,
    input logic [W-1:0] enc_neg,
    input logic [W-1:0] line_pos,
    input logic [W-1:0] line_neg,
    input logic [W-1:0] dec_pos,
    input logic [W-1:0] dec_neg,
    input logic         err_applied,
    input logic         lp_conflict,
    input lp_mode_e     mode,
    input alarm_e       alarm,
    input logic         los
);
    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_sync |=> $stable(mode));

    assert_src_ais_loop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SOURCE && alarm == ALM_AIS) |=>
            (dec_pos == $past(enc_pos) && dec_neg == $past(enc_neg)));

    assert_los_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        los |=> (line_pos == '0 && line_neg == '0));

    assert_err_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_applied && ($past(mode) == MODE_NORMAL || $past(mode) == MODE_SOURCE)) |->
            (line_pos[0] != $past(enc_pos[0])));

    assert_err_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (los || alarm != ALM_NONE) |=> !err_applied);

    assert_shallow_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_sync && cfg_shallow_lp) |=> (mode == MODE_SHALLOW));

    assert_conflict_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lp_conflict |=> lp_conflict);

    assert_conflict_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_sync && cfg_shallow_lp && cfg_src_lp) |=> lp_conflict);
endmodule

bind lpbk_alarm_path lpbk_alarm_path_chk #(.W(W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .frame_sync     (frame_sync),
    .cfg_src_lp     (cfg_src_lp),
    .cfg_shallow_lp (cfg_shallow_lp),
    .enc_pos        (enc_pos),
    .enc_neg        (enc_neg),
    .line_pos       (line_pos),
    .line_neg       (line_neg),
    .dec_pos        (dec_pos),
    .dec_neg        (dec_neg),
    .err_applied    (err_applied),
    .lp_conflict    (lp_conflict),
    .mode           (mode_q),
    .alarm          (alarm_q),
    .los            (los_q)
);

// File: tb/lpbk_alarm_path_tb_top.sv
module lpbk_alarm_path_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         frame_sync, cfg_src_lp, cfg_shallow_lp, cfg_payload_lp, cfg_los, err_req;
    logic [1:0]   cfg_alarm;
    logic [W-1:0] enc_pos, enc_neg, rx_pos, rx_neg;
    logic [W-1:0] line_pos, line_neg, dec_pos, dec_neg;
    logic         err_applied, lp_conflict;

    int errors = 0;
    int checks = 0;

    // bench model of the active configuration: 0 normal, 1 source, 2 shallow, 3 payload
    int         m_mode;
    logic [1:0] m_alarm;
    logic       m_los;
    logic       m_conf;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpbk_alarm_path #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
        .cfg_src_lp(cfg_src_lp), .cfg_shallow_lp(cfg_shallow_lp),
        .cfg_payload_lp(cfg_payload_lp), .cfg_alarm(cfg_alarm), .cfg_los(cfg_los),
        .err_req(err_req), .enc_pos(enc_pos), .enc_neg(enc_neg),
        .rx_pos(rx_pos), .rx_neg(rx_neg), .line_pos(line_pos), .line_neg(line_neg),
        .dec_pos(dec_pos), .dec_neg(dec_neg), .err_applied(err_applied),
        .lp_conflict(lp_conflict)
    );

    function automatic logic [W-1:0] idle_word(input bit odd);
        logic [W-1:0] v;
        for (int i = 0; i < W; i++) v[i] = ((i % 2) == 1) == odd;
        return v;
    endfunction

    // expected {line_pos, line_neg, dec_pos, dec_neg, err_applied}
    function automatic logic [4*W:0] model(input int md, input logic [1:0] al, input logic ls,
                                           input logic er, input logic [W-1:0] ep, en, rp, rn);
        logic [W-1:0] lp, ln, dp, dn, src_p, src_n;
        logic eok;
        eok = er && (md != 2) && !ls && (al == 2'b00);
        src_p = (md == 3) ? rp : ep;
        src_n = (md == 3) ? rn : en;
        if (eok) src_p[0] = ~src_p[0];
        if (ls)              begin lp = '0; ln = '0; end
        else if (md == 2)    begin lp = rp; ln = rn; end
        else if (al == 2'b01) begin lp = '1; ln = '0; end
        else if (al == 2'b10) begin lp = idle_word(1'b1); ln = idle_word(1'b0); end
        else if (al == 2'b11) begin lp = '0; ln = '1; end
        else                 begin lp = src_p; ln = src_n; end
        if (md == 1) begin
            if (al == 2'b10)      begin dp = idle_word(1'b1); dn = idle_word(1'b0); end
            else if (al == 2'b11) begin dp = '0; dn = '1; end
            else begin dp = ep; dn = en; if (eok) dp[0] = ~dp[0]; end
        end else begin
            dp = rp; dn = rn;
        end
        return {lp, ln, dp, dn, eok};
    endfunction

    task automatic check_out(input logic [4*W:0] exp_v, input logic exp_c, input string tag);
        logic [4*W:0] act;
        act = {line_pos, line_neg, dec_pos, dec_neg, err_applied};
        checks++;
        if (act !== exp_v || lp_conflict !== exp_c) begin
            errors++;
            $display("FAIL %s: actual=%h conflict=%b expected=%h conflict=%b",
                     tag, act, lp_conflict, exp_v, exp_c);
        end
    endtask

    task automatic step(input logic sy, sr, sh, pl, input logic [1:0] al, input logic ls, er,
                        input logic [W-1:0] ep, en, rp, rn, input string tag);
        logic [4*W:0] e;
        frame_sync = sy; cfg_src_lp = sr; cfg_shallow_lp = sh; cfg_payload_lp = pl;
        cfg_alarm = al; cfg_los = ls; err_req = er;
        enc_pos = ep; enc_neg = en; rx_pos = rp; rx_neg = rn;
        e = model(m_mode, m_alarm, m_los, er, ep, en, rp, rn);
        @(posedge clk);
        if (sy) begin
            if (sh) m_mode = 2; else if (sr) m_mode = 1; else if (pl) m_mode = 3; else m_mode = 0;
            m_alarm = al; m_los = ls;
            if (sh && sr) m_conf = 1'b1;
        end
        @(negedge clk);
        check_out(e, m_conf, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h2C0F_FEE5));
        rst_n = 1'b0;
        frame_sync = 1; cfg_src_lp = 1; cfg_shallow_lp = 0; cfg_payload_lp = 0;
        cfg_alarm = 2'b01; cfg_los = 0; err_req = 1;
        enc_pos = 8'h5A; enc_neg = 8'h3C; rx_pos = 8'hC3; rx_neg = 8'h81;
        m_mode = 0; m_alarm = 0; m_los = 0; m_conf = 0;
        repeat (3) @(negedge clk);
        check_out('0, 1'b0, "R1 reset");
        rst_n = 1'b1;

        // R10 normal path, R2 requests without strobe ignored
        step(0, 0, 0, 0, 2'b00, 0, 0, 8'h12, 8'h34, 8'h56, 8'h78, "R10 normal");
        step(0, 1, 0, 0, 2'b01, 1, 0, 8'hA1, 8'h1A, 8'hB2, 8'h2B, "R2 no strobe");
        step(0, 0, 0, 0, 2'b00, 0, 0, 8'hA1, 8'h1A, 8'hB2, 8'h2B, "R2 held normal");
        // R3 source loopback
        step(1, 1, 0, 0, 2'b00, 0, 0, 8'hF0, 8'h0F, 8'h11, 8'h22, "R2 strobe source");
        step(0, 0, 0, 0, 2'b00, 0, 0, 8'h96, 8'h69, 8'h11, 8'h22, "R3 source");
        step(0, 0, 0, 0, 2'b00, 0, 1, 8'h96, 8'h69, 8'h11, 8'h22, "R7 err source");
        // R4 AIS in source with error dropped
        step(1, 1, 0, 0, 2'b01, 0, 0, 8'h96, 8'h69, 8'h11, 8'h22, "R4 strobe AIS");
        step(0, 0, 0, 0, 2'b00, 0, 1, 8'h3E, 8'hC1, 8'h11, 8'h22, "R4 AIS line only, R7 gated");
        // R5 LOS in source
        step(1, 1, 0, 0, 2'b00, 1, 0, 8'h3E, 8'hC1, 8'h11, 8'h22, "R5 strobe LOS");
        step(0, 0, 0, 0, 2'b00, 0, 1, 8'h77, 8'h88, 8'h11, 8'h22, "R5 LOS line zero, R7 gated");
        // R6 idle and RAI reach both paths
        step(1, 1, 0, 0, 2'b10, 0, 0, 8'h77, 8'h88, 8'h11, 8'h22, "R6 strobe idle");
        step(0, 0, 0, 0, 2'b00, 0, 1, 8'h77, 8'h88, 8'h11, 8'h22, "R6 idle both");
        step(1, 1, 0, 0, 2'b11, 1, 0, 8'h77, 8'h88, 8'h11, 8'h22, "R6 strobe RAI+LOS");
        step(0, 0, 0, 0, 2'b00, 0, 0, 8'h77, 8'h88, 8'h11, 8'h22, "R6 RAI loop, LOS line");
        // R8 payload loopback
        step(1, 0, 0, 1, 2'b00, 0, 0, 8'h01, 8'h02, 8'h40, 8'h80, "R8 strobe payload");
        step(0, 0, 0, 0, 2'b00, 0, 1, 8'h01, 8'h02, 8'h40, 8'h80, "R8 payload err");
        step(1, 0, 0, 1, 2'b10, 1, 0, 8'h01, 8'h02, 8'h40, 8'h80, "R8 strobe LOS");
        step(0, 0, 0, 0, 2'b00, 0, 0, 8'h01, 8'h02, 8'h40, 8'h80, "R8 LOS over idle");
        // R9 shallow wins and conflict sticks
        step(1, 1, 1, 1, 2'b01, 0, 0, 8'hDE, 8'hAD, 8'hBE, 8'hEF, "R9 strobe conflict");
        step(0, 0, 0, 0, 2'b00, 0, 1, 8'hDE, 8'hAD, 8'hBE, 8'hEF, "R9 shallow line=rx");
        step(1, 0, 0, 0, 2'b00, 0, 0, 8'hDE, 8'hAD, 8'hBE, 8'hEF, "R9 strobe normal");
        step(0, 0, 0, 0, 2'b00, 0, 0, 8'hDE, 8'hAD, 8'hBE, 8'hEF, "R9 conflict sticky");

        for (int n = 0; n < 3000; n++) begin
            string tg;
            tg = (m_mode == 1) ? "R3 rand source" : (m_mode == 2) ? "R9 rand shallow" :
                 (m_mode == 3) ? "R8 rand payload" : "R10 rand normal";
            step(($urandom % 4) == 0, $urandom % 2, ($urandom % 8) == 0, $urandom % 2,
                 2'($urandom), ($urandom % 5) == 0, $urandom % 2,
                 W'($urandom), W'($urandom), W'($urandom), W'($urandom), tg);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule